// File: doc/BRIEF.md
# Alternating Half-Bridge Gate Pulse Generator

This block produces the two digital gate-drive commands of a half-bridge power stage. A ramp counter counts from zero up to a programmable terminal count and then wraps; each pass of the counter is one oscillator cycle. Cycles alternate between a low-side cycle and a high-side cycle. Only the low-side command may pulse in a low-side cycle, and only the high-side command in a high-side cycle. Each command therefore runs at half the oscillator rate, and one full switching period is two oscillator cycles.

Inside its own cycle, a command goes high at count zero and stays high while the count is below an effective threshold. That threshold is the smallest of three values: the soft-start code, the duty-limit code and the terminal count. While the soft-start code ramps up, it sets the pulse width. Once it passes the duty limit, the limit sets the width. Clamping to the terminal count keeps at least one low count at the end of every cycle, so each command stays below half of the switching period. The threshold and the terminal count are captured only when a cycle begins.

When the enable input drops, both commands are held low. When enable rises, or when the phase-reset strobe is pulsed, switching starts again with a low-side cycle, so the low-side command always fires first. A one-clock start-of-period mark flags the first count of every low-side cycle for the fault logic.

Top module: `hb_pwm_gen`

## Requirements
- R1: While reset is asserted, and in the first clock after it, all four outputs are low.
- R2: In the clock after a clock edge that samples `en` low, `drv_lo`, `drv_hi`, `hi_phase` and `period_start` are all low.
- R3: Oscillator cycles alternate. `hi_phase` is 0 in a low-side cycle and 1 in a high-side cycle. `drv_lo` is high only when `hi_phase` is 0, and `drv_hi` is high only when `hi_phase` is 1.
- R4: Each command gives at most one pulse per switching period, so its repetition rate is half the oscillator rate.
- R5: In every cycle, the command for that cycle is high at counts 0 through T-1 and low after that, where T = min(`ss_level`, `duty_max`, `term_count`).
- R6: A soft-start code of 0 gives no pulse on either command.
- R7: The threshold inputs and `term_count` are captured at the first count of each cycle. A change later in the cycle leaves the current pulse unchanged.
- R8: The first clock edge that samples `en` high after `en` was low starts a low-side cycle at count 0, with `drv_lo` high right away if T > 0.
- R9: A clock edge that samples `phase_rst` high while `en` is high restarts at count 0 of a low-side cycle.
- R10: `period_start` is high for exactly one clock, the first count of every low-side cycle.
- R11: Each oscillator cycle lasts `term_count`+1 clocks, using the value captured at its start, so a switching period lasts 2·(`term_count`+1) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Global enable; low holds both commands off |
| phase_rst | input | 1 | Strobe forcing a new low-side cycle |
| ss_level | input | CNT_W | Soft-start code |
| duty_max | input | CNT_W | Maximum-duty code |
| term_count | input | CNT_W | Ramp terminal count (last count of a cycle) |
| drv_lo | output | 1 | Low-side gate command |
| drv_hi | output | 1 | High-side gate command |
| hi_phase | output | 1 | 1 during a high-side cycle |
| period_start | output | 1 | One-clock mark at the start of each low-side cycle |

## Verification
All four outputs are decoded from registers only. A change on any input therefore shows up in the clock that follows the edge that samples it. The exception is threshold and terminal-count inputs, which show up only in the clock after the next cycle-start edge. The bench drives inputs just after a falling edge and runs a behavioural reference model on the rising edge. It compares every output at the following falling edge, so each expectation is checked in the first clock where the result is due. Directed measurements of pulse width, period length and the first output after an enable or phase reset start counting at a `period_start` mark. This makes the number of clocks from the stimulus to each result exact.

// File: rtl/hb_pwm_pkg.sv
// Shared definitions for the alternating half-bridge pulse generator.
// Assumes: two gate commands, indexed by the side of the bridge they drive.
package hb_pwm_pkg;
    // Which side of the bridge owns the current oscillator cycle
    typedef enum logic {
        SIDE_LO = 1'b0,
        SIDE_HI = 1'b1
    } side_e;

    // Number of gate commands interleaved by the generator
    localparam int unsigned NUM_SIDES = 2;
endpackage

// File: rtl/hb_pwm_ramp.sv
// Ramp counter: counts 0..captured terminal count, then wraps.
// Assumes: start_i is asserted by the sequencer on every cycle start; the
// terminal count is captured only at that moment.
module hb_pwm_ramp #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    // Advance the ramp, restart it at cycle start, clear it when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (!en_i) begin
            cnt_q  <= '0;
        end else if (start_i) begin
            cnt_q  <= '0;
            last_q <= term_i;
        end else begin
            cnt_q  <= cnt_q + ONE;
        end
    end

    // Final count of the current cycle reached
    always_comb wrap_o = (cnt_q == last_q);
    always_comb cnt_o  = cnt_q;

    // Between restarts the ramp only ever steps up by one (R11)
    assert_ramp_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !start_i) |=> (cnt_o == $past(cnt_o) + ONE));
endmodule

// File: rtl/hb_pwm_seq.sv
// Cycle sequencer: tracks run state and which side owns the cycle.
// Assumes: wrap_i is high on the last count of a cycle. The enable edge and
// the phase-reset strobe both force a low-side cycle.
module hb_pwm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic phase_rst_i,
    input  logic wrap_i,
    output logic start_o,
    output logic active_o,
    output hb_pwm_pkg::side_e side_o
);
    import hb_pwm_pkg::*;

    logic  active_q;
    side_e side_q;
    logic  force_lo;

    // A new cycle begins on first enable, on a phase reset, or at ramp wrap
    always_comb begin
        force_lo = !active_q || phase_rst_i;
        start_o  = en_i && (force_lo || wrap_i);
    end

    // Update run state and cycle ownership
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            side_q   <= SIDE_LO;
        end else if (!en_i) begin
            active_q <= 1'b0;
            side_q   <= SIDE_LO;
        end else if (start_o) begin
            active_q <= 1'b1;
            side_q   <= force_lo ? SIDE_LO
                                 : ((side_q == SIDE_LO) ? SIDE_HI : SIDE_LO);
        end
    end

    always_comb begin
        active_o = active_q;
        side_o   = side_q;
    end

    // A natural wrap hands the next cycle to the other side (R3)
    assert_side_alternates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && active_q && wrap_i && !phase_rst_i) |=> (side_q != $past(side_q)));
endmodule

// File: rtl/hb_pwm_limit.sv
// Threshold limiter: picks the smallest of soft-start, duty limit and
// terminal count, and holds it for a whole cycle.
// Assumes: start_i marks the clock edge that begins a cycle.
module hb_pwm_limit #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] ss_i,
    input  logic [CNT_W-1:0] dmax_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] thr_o
);
    logic [CNT_W-1:0] lim_ramp;
    logic [CNT_W-1:0] lim_eff;
    logic [CNT_W-1:0] thr_q;

    // Soft-start governs until it passes the duty limit; keep one idle count
    always_comb begin
        lim_ramp = (ss_i < dmax_i) ? ss_i : dmax_i;
        lim_eff  = (lim_ramp < term_i) ? lim_ramp : term_i;
    end

    // Capture the threshold only at a cycle boundary
    always_ff @(posedge clk) begin
        if (!rst_n)       thr_q <= '0;
        else if (start_i) thr_q <= lim_eff;
    end

    always_comb thr_o = thr_q;

    // Captured threshold never exceeds the duty limit (R5)
    assert_thr_limited_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (thr_o <= $past(dmax_i) && thr_o <= $past(ss_i)));
endmodule

// File: rtl/hb_pwm_out.sv
// Output stage: decodes the gate commands and the period mark from the
// registered ramp, side and threshold.
// Assumes: all inputs come straight from registers.
module hb_pwm_out #(
    parameter int unsigned CNT_W = 8
) (
    input  logic              active_i,
    input  hb_pwm_pkg::side_e side_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CNT_W-1:0]  thr_i,
    output logic [hb_pwm_pkg::NUM_SIDES-1:0] drv_o,
    output logic              hi_phase_o,
    output logic              period_start_o
);
    import hb_pwm_pkg::*;

    logic on_time;

    // Ramp still below the captured threshold
    always_comb on_time = active_i && (cnt_i < thr_i);

    // One gate command per bridge side, each gated by cycle ownership
    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_side
        always_comb drv_o[g] = on_time && (side_i == side_e'(g));
    end

    // Cycle flag and start-of-period mark
    always_comb begin
        hi_phase_o     = active_i && (side_i == SIDE_HI);
        period_start_o = active_i && (side_i == SIDE_LO) && (cnt_i == '0);
    end
endmodule

// File: rtl/hb_pwm_gen.sv
// Alternating half-bridge PWM generator (top).
// Low-side and high-side commands pulse on alternate ramp cycles. The width
// is the smallest of soft-start, duty limit and terminal count.
// Assumes: synchronous active-low reset; all outputs are decoded from registers.
module hb_pwm_gen #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             phase_rst,
    input  logic [CNT_W-1:0] ss_level,
    input  logic [CNT_W-1:0] duty_max,
    input  logic [CNT_W-1:0] term_count,
    output logic             drv_lo,
    output logic             drv_hi,
    output logic             hi_phase,
    output logic             period_start
);
    import hb_pwm_pkg::*;

    logic             start;
    logic             active;
    side_e            side;
    logic             wrap;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] thr;
    logic [NUM_SIDES-1:0] drv;

    hb_pwm_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .phase_rst_i (phase_rst),
        .wrap_i      (wrap),
        .start_o     (start),
        .active_o    (active),
        .side_o      (side)
    );

    hb_pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .start_i (start),
        .term_i  (term_count),
        .cnt_o   (cnt),
        .wrap_o  (wrap)
    );

    hb_pwm_limit #(.CNT_W(CNT_W)) u_limit (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .ss_i    (ss_level),
        .dmax_i  (duty_max),
        .term_i  (term_count),
        .thr_o   (thr)
    );

    hb_pwm_out #(.CNT_W(CNT_W)) u_out (
        .active_i       (active),
        .side_i         (side),
        .cnt_i          (cnt),
        .thr_i          (thr),
        .drv_o          (drv),
        .hi_phase_o     (hi_phase),
        .period_start_o (period_start)
    );

    // Map per-side commands to the named ports
    always_comb begin
        drv_lo = drv[SIDE_LO];
        drv_hi = drv[SIDE_HI];
    end

    // Disabled means silent in the next clock (R2)
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!drv_lo && !drv_hi && !hi_phase && !period_start));

    // Phase reset lands on the first count of a low-side cycle (R9)
    assert_restart_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && phase_rst) |=> (period_start && !hi_phase));

    // Enable edge starts with the low side (R8)
    assert_first_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !active) |=> (period_start && !drv_hi));

    // Period mark is never held for two clocks (R10)
    assert_mark_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && term_count != '0 && en && !phase_rst) |=> !period_start);
endmodule

// File: tb/test_hb_pwm_gen.sv
// Self-checking bench with a behavioural reference model compared every clock.
module test_hb_pwm_gen;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             phase_rst = 1'b0;
    logic [CNT_W-1:0] ss_level = '0;
    logic [CNT_W-1:0] duty_max = '0;
    logic [CNT_W-1:0] term_count = '0;
    logic drv_lo, drv_hi, hi_phase, period_start;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hb_pwm_gen #(.CNT_W(CNT_W)) i_hb_pwm_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .phase_rst(phase_rst),
        .ss_level(ss_level), .duty_max(duty_max), .term_count(term_count),
        .drv_lo(drv_lo), .drv_hi(drv_hi), .hi_phase(hi_phase),
        .period_start(period_start)
    );

    // Reference model state
    int  m_cnt = 0, m_thr = 0, m_last = 0;
    bit  m_run = 0, m_hi = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_hi = 0; m_cnt = 0; m_thr = 0; m_last = 0;
        end else if (!en) begin
            m_run = 0; m_hi = 0; m_cnt = 0;
        end else if (!m_run || phase_rst || m_cnt == m_last) begin
            int lim;
            m_hi  = (!m_run || phase_rst) ? 1'b0 : !m_hi;
            m_run = 1;
            m_cnt = 0;
            lim = int'(ss_level);
            if (int'(duty_max) < lim) lim = int'(duty_max);
            if (int'(term_count) < lim) lim = int'(term_count);
            m_thr  = lim;
            m_last = int'(term_count);
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            bit on;
            on = m_run && (m_cnt < m_thr);
            if (!en && !m_run) begin
                check("R2", "drv_lo off", int'(drv_lo), 0);
                check("R2", "drv_hi off", int'(drv_hi), 0);
            end else begin
                check("R5", "drv_lo", int'(drv_lo), int'(on && !m_hi));
                check("R5", "drv_hi", int'(drv_hi), int'(on && m_hi));
            end
            check("R3", "hi_phase", int'(hi_phase), int'(m_run && m_hi));
            check("R10", "period_start", int'(period_start),
                  int'(m_run && !m_hi && m_cnt == 0));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    // Wait for a start-of-period mark seen strictly after the current clock
    task automatic wait_start();
        tick();
        for (int i = 0; i < 2000 && !period_start; i++) tick();
    endtask

    // From a period mark: widths on each side and switching-period length
    task automatic measure(output int wl, output int wh, output int len);
        wl = 0; wh = 0; len = 0;
        for (int i = 0; i < 1000; i++) begin
            if (drv_lo) wl++;
            if (drv_hi) wh++;
            if (drv_lo && hi_phase) check("R3", "drv_lo in high cycle", 1, 0);
            len++;
            tick();
            if (period_start) break;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int wl, wh, len, pulses;
        // R1: reset state
        repeat (3) tick();
        check("R1", "drv_lo in reset", int'(drv_lo), 0);
        check("R1", "drv_hi in reset", int'(drv_hi), 0);
        check("R1", "period_start in reset", int'(period_start), 0);
        rst_n = 1'b1;
        tick();
        check("R1", "hi_phase after reset", int'(hi_phase), 0);
        repeat (4) tick();

        // R8: enable edge starts a low-side cycle with drv_lo high
        ss_level = 8'd5; duty_max = 8'd9; term_count = 8'd15;
        en = 1'b1;
        tick();
        check("R8", "period_start first", int'(period_start), 1);
        check("R8", "drv_lo first", int'(drv_lo), 1);
        check("R8", "drv_hi first", int'(drv_hi), 0);
        measure(wl, wh, len);
        check("R5", "width ss-limited lo", wl, 5);
        check("R5", "width ss-limited hi", wh, 5);
        check("R11", "period length", len, 32);
        check("R4", "one pulse per side per period", wl > 0 && wh > 0 ? 1 : 0, 1);

        // R5: duty limit takes over
        ss_level = 8'd12; duty_max = 8'd7;
        wait_start();
        measure(wl, wh, len);
        check("R5", "width duty-limited", wl, 7);
        check("R5", "width duty-limited hi", wh, 7);

        // R5/R11: clamp to terminal count, new period length
        ss_level = 8'd40; duty_max = 8'd40; term_count = 8'd9;
        wait_start();
        measure(wl, wh, len);
        check("R5", "width clamped to terminal", wl, 9);
        check("R11", "period length new terminal", len, 20);

        // R7: mid-cycle change does not touch the running pulse
        ss_level = 8'd6;
        wait_start();
        ss_level = 8'd2;
        measure(wl, wh, len);
        check("R7", "lo width keeps captured value", wl, 6);
        check("R7", "hi width takes new value", wh, 2);

        // R6: zero soft-start gives no pulses
        ss_level = 8'd0;
        wait_start();
        pulses = 0;
        for (int i = 0; i < 60; i++) begin
            if (drv_lo || drv_hi) pulses++;
            tick();
        end
        check("R6", "no pulses at zero soft-start", pulses, 0);

        // R9: phase reset during a high-side cycle
        ss_level = 8'd4;
        wait_start();
        for (int i = 0; i < 200 && !hi_phase; i++) tick();
        repeat (2) tick();
        phase_rst = 1'b1;
        tick();
        phase_rst = 1'b0;
        check("R9", "restart low side", int'(hi_phase), 0);
        check("R9", "restart mark", int'(period_start), 1);
        check("R9", "restart drv_lo", int'(drv_lo), 1);

        // R2: drop enable mid-pulse
        tick();
        en = 1'b0;
        tick();
        check("R2", "drv_lo after disable", int'(drv_lo), 0);
        check("R2", "hi_phase after disable", int'(hi_phase), 0);
        repeat (10) tick();

        // R8: re-enable begins with low side again
        en = 1'b1;
        tick();
        check("R8", "re-enable low side", int'(drv_lo), 1);
        repeat (30) tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule